// File: doc/BRIEF.md
# Way-Memoizing Set-Associative Instruction Cache

This block is a 4-way set-associative instruction cache for a single-issue, in-order fetch stage. It remembers which way it used last. Each cache line carries a small link field: a valid flag and the way number that holds the next sequential line. When fetch moves from one line into the following line and that link is valid, the access compares no tags. It enables only the data way that the link names. The access still completes in the same single cycle as an ordinary hit.

A branch target buffer outside the block can supply a way hint with a fetch on a taken branch. It can also learn way numbers from the response port. Every refill overwrites one line. The block broadcasts the set and way it replaced, so that the branch target buffer can drop its stale pointers. Inside the block, the same event clears every link that recorded that set and way.

A miss stalls fetch while the line is refilled from a fixed-latency memory. Victims are chosen by a round-robin pointer that each set keeps for itself. Each response reports how many tag comparisons and data-way enables the access used, so that the energy saving can be observed directly at the ports.

Top module: `waymemo_icache`

## Requirements
- R1: After reset, fetch_ready is 1, and resp_valid, mem_req and evict_valid are 0.
- R2: Addresses are word addresses. Bits [1:0] select the word in a 4-word line, bits [4:2] the set, and bits [11:5] the tag. An access with no usable way memory reads all 4 ways and compares all 4 tags. On a hit, resp_valid is 1 in the cycle after acceptance, with the addressed word, the hit way, resp_memo=0, resp_tag_cmps=4 and resp_way_ens=4.
- R3: On a miss, fetch_ready drops and mem_req is held with the line address (address bits [11:2]) until mem_ack arrives. The response comes one cycle after mem_ack and carries the addressed word of the refill line, the filled way, resp_memo=0 and counts of 4 and 4.
- R4: The victim way for each set follows round-robin order starting at way 0. A set's pointer advances only on refills into that set.
- R5: Every refill raises evict_valid for exactly one cycle, in the same cycle as the response, with the set and way that were overwritten.
- R6: An access to the same line as the previous accepted access reuses the previous way: resp_memo=1, 0 tag compares, 1 way enable.
- R7: A sequential line crossing is an access whose line address is the previous line address plus one, with the set wrapping from 7 to 0. When such an access is resolved by tag compare or by refill, the way it resolved to is stored in the previous line's link field.
- R8: A sequential line crossing whose previous line has a valid link is served from the linked way, with resp_memo=1, 0 tag compares and 1 way enable.
- R9: A fetch with fetch_hint_valid=1 is served from fetch_hint_way with 0 tag compares and 1 way enable. A hint takes priority over any stored way memory.
- R10: A refill into set s, way w clears every link held in set (s-1) mod 8 that records way w. A later crossing into that set falls back to tag compare.
- R11: Memoized hits add no cycles. Back-to-back fetches are accepted every cycle, and each response appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | 12 | Word address to fetch |
| fetch_hint_valid | input | 1 | External way hint present (taken branch) |
| fetch_hint_way | input | 2 | Way named by the external hint |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| resp_valid | output | 1 | Response valid |
| resp_data | output | 32 | Fetched instruction word |
| resp_way | output | 2 | Way that served the fetch |
| resp_memo | output | 1 | Served from way memory, no tag compare |
| resp_tag_cmps | output | 3 | Tag comparisons used by this access |
| resp_way_ens | output | 3 | Data ways enabled by this access |
| mem_req | output | 1 | Refill request, held until acknowledged |
| mem_line | output | 10 | Line address being refilled |
| mem_ack | input | 1 | Refill data present on mem_rdata |
| mem_rdata | input | 128 | Full refill line, word 0 in the low bits |
| evict_valid | output | 1 | A line slot was overwritten |
| evict_set | output | 3 | Set of the overwritten slot |
| evict_way | output | 2 | Way of the overwritten slot |

## Verification
The way-selection logic is driven with four kinds of fetch sequence. Cold misses separate the refill path from lookup. Repeated words inside one line exercise reuse of the previous way. Sequential runs across line boundaries, including the wrap from the last set to set 0, show whether a link was learned and then used. Out-of-order returns to resident lines show plain tag compare. Taken-branch style fetches with an external hint show that the hint overrides the stored links. One set is filled past its capacity so that the victim walks all four ways and overwrites a line that another line's link points to. The fetch that follows must miss and refill, not read the stale way. A continuous stream of eight fetches confirms that memoized accesses keep single-cycle throughput.

// File: rtl/wm_pkg.sv
package wm_pkg;

  // Controller phase: lookup accepts fetches, refill waits for memory.
  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } wm_state_e;

  // Where the way for the current access comes from.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HINT = 2'd1,
    SRC_SAME = 2'd2,
    SRC_LINK = 2'd3
  } wm_src_e;

endpackage

// File: rtl/wm_tag_store.sv
module wm_tag_store #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 7,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  hit_vec,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
        end
      end
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
      tag_q[wr_set][wr_way] <= wr_tag;
    end
  end

  // One comparator per way, all active in parallel.
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[rd_set][g] && (tag_q[rd_set][g] == rd_tag);
  end

endmodule

// File: rtl/wm_data_store.sv
module wm_data_store #(
  parameter int SETS       = 8,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int LINE_B = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_B-1:0] wr_line
);

  logic [WORD_W-1:0] mem_q [SETS][WAYS][LINE_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < LINE_WORDS; k++) begin
        mem_q[wr_set][wr_way][k] <= wr_line[k*WORD_W +: WORD_W];
      end
    end
  end

  assign rd_word = mem_q[rd_set][rd_way][rd_off];

endmodule

// File: rtl/wm_link_store.sv
module wm_link_store #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // read of the link held by one line
  input  logic [IDX_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_way,
  output logic             rd_valid,
  output logic [WAY_W-1:0] rd_target,
  // learn: record the way of the successor line
  input  logic             lw_en,
  input  logic [IDX_W-1:0] lw_set,
  input  logic [WAY_W-1:0] lw_way,
  input  logic [WAY_W-1:0] lw_target,
  // refill of slot (fill_set, fill_way)
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way
);

  logic             lv_q [SETS][WAYS];
  logic [WAY_W-1:0] lt_q [SETS][WAYS];
  logic [IDX_W-1:0] pred_set;

  // Lines whose successor maps into fill_set live one set below it.
  assign pred_set = fill_set - IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          lv_q[s][w] <= 1'b0;
          lt_q[s][w] <= '0;
        end
      end
    end else begin
      if (fill_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (lt_q[pred_set][w] == fill_way) lv_q[pred_set][w] <= 1'b0;
        end
        lv_q[fill_set][fill_way] <= 1'b0;
      end
      // Learning is issued last so a link to the freshly filled line survives.
      if (lw_en) begin
        lv_q[lw_set][lw_way] <= 1'b1;
        lt_q[lw_set][lw_way] <= lw_target;
      end
    end
  end

  assign rd_valid  = lv_q[rd_set][rd_way];
  assign rd_target = lt_q[rd_set][rd_way];

endmodule

// File: rtl/wm_victim_rr.sv
module wm_victim_rr #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel_set,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);

  logic [WAY_W-1:0] ptr_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[s] <= '0;
      end else if (advance && (sel_set == IDX_W'(s))) begin
        ptr_q[s] <= (ptr_q[s] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[s] + WAY_W'(1);
      end
    end
  end

  assign victim = ptr_q[sel_set];

endmodule

// File: rtl/waymemo_icache.sv
module waymemo_icache
  import wm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  parameter int WAYS       = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = LINE_W - IDX_W,
  localparam int CNT_W  = $clog2(WAYS + 1),
  localparam int LINE_B = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_hint_valid,
  input  logic [WAY_W-1:0]  fetch_hint_way,
  output logic              fetch_ready,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_data,
  output logic [WAY_W-1:0]  resp_way,
  output logic              resp_memo,
  output logic [CNT_W-1:0]  resp_tag_cmps,
  output logic [CNT_W-1:0]  resp_way_ens,
  output logic              mem_req,
  output logic [LINE_W-1:0] mem_line,
  input  logic              mem_ack,
  input  logic [LINE_B-1:0] mem_rdata,
  output logic              evict_valid,
  output logic [IDX_W-1:0]  evict_set,
  output logic [WAY_W-1:0]  evict_way
);

  // ---------------- address arithmetic ----------------
  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return LINE_W'(a >> OFF_W);
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return OFF_W'(a);
  endfunction

  function automatic logic [IDX_W-1:0] set_of(input logic [LINE_W-1:0] l);
    return IDX_W'(l);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] l);
    return TAG_W'(l >> IDX_W);
  endfunction

  function automatic logic [LINE_W-1:0] succ_line(input logic [LINE_W-1:0] l);
    return l + LINE_W'(1);
  endfunction

  function automatic logic [WAY_W-1:0] way_index(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (v[i]) r = r | WAY_W'(i);
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_B-1:0] ln,
                                                input logic [OFF_W-1:0]  o);
    return WORD_W'(ln >> (int'(o) * WORD_W));
  endfunction

  // ---------------- state ----------------
  wm_state_e         state_q;
  logic              prev_ok_q;
  logic [LINE_W-1:0] prev_line_q;
  logic [WAY_W-1:0]  prev_way_q;
  logic [LINE_W-1:0] pend_line_q;
  logic [OFF_W-1:0]  pend_off_q;
  logic              pend_seq_q;

  // ---------------- named internal events ----------------
  logic [LINE_W-1:0] cur_line;
  logic [IDX_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [OFF_W-1:0]  cur_off;
  logic              same_line;
  logic              seq_cross;
  logic              link_valid;
  logic [WAY_W-1:0]  link_target;
  wm_src_e           memo_src;
  logic [WAY_W-1:0]  memo_way;
  logic              memo_use;
  logic [WAYS-1:0]   hit_vec;
  logic              tag_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  use_way;
  logic [WAYS-1:0]   way_en;
  logic              accept;
  logic              acc_hit;
  logic              acc_miss;
  logic              fill_done;
  logic [WAY_W-1:0]  victim;
  logic [WORD_W-1:0] rd_word;
  logic              learn_en;
  logic [WAY_W-1:0]  learn_target;
  logic [IDX_W-1:0]  pend_set;

  assign cur_line  = line_of(fetch_addr);
  assign cur_set   = set_of(cur_line);
  assign cur_tag   = tag_of(cur_line);
  assign cur_off   = off_of(fetch_addr);
  assign pend_set  = set_of(pend_line_q);

  assign same_line = prev_ok_q && (cur_line == prev_line_q);
  assign seq_cross = prev_ok_q && (cur_line == succ_line(prev_line_q));

  // Way memory selection, hint first.
  always_comb begin
    memo_src = SRC_NONE;
    memo_way = '0;
    if (fetch_hint_valid) begin
      memo_src = SRC_HINT;
      memo_way = fetch_hint_way;
    end else if (same_line) begin
      memo_src = SRC_SAME;
      memo_way = prev_way_q;
    end else if (seq_cross && link_valid) begin
      memo_src = SRC_LINK;
      memo_way = link_target;
    end
  end

  assign memo_use = (memo_src != SRC_NONE);
  assign tag_hit  = |hit_vec;
  assign hit_way  = way_index(hit_vec);
  assign use_way  = memo_use ? memo_way : hit_way;

  always_comb begin
    way_en = '1;
    if (memo_use) begin
      way_en = '0;
      way_en[memo_way] = 1'b1;
    end
  end

  assign fetch_ready = (state_q == ST_LOOKUP);
  assign accept      = fetch_valid && fetch_ready;
  assign acc_hit     = accept && (memo_use || tag_hit);
  assign acc_miss    = accept && !(memo_use || tag_hit);
  assign fill_done   = (state_q == ST_REFILL) && mem_ack;

  // Link learning after a compare-resolved crossing, or after its refill.
  assign learn_en     = (acc_hit && seq_cross && !memo_use) || (fill_done && pend_seq_q);
  assign learn_target = fill_done ? victim : hit_way;

  assign mem_req  = (state_q == ST_REFILL);
  assign mem_line = pend_line_q;

  // ---------------- storage ----------------
  wm_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (cur_set),
    .rd_tag  (cur_tag),
    .hit_vec (hit_vec),
    .wr_en   (fill_done),
    .wr_set  (pend_set),
    .wr_way  (victim),
    .wr_tag  (tag_of(pend_line_q))
  );

  wm_data_store #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
    .clk     (clk),
    .rd_set  (cur_set),
    .rd_way  (use_way),
    .rd_off  (cur_off),
    .rd_word (rd_word),
    .wr_en   (fill_done),
    .wr_set  (pend_set),
    .wr_way  (victim),
    .wr_line (mem_rdata)
  );

  wm_link_store #(.SETS(SETS), .WAYS(WAYS)) u_links (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (set_of(prev_line_q)),
    .rd_way    (prev_way_q),
    .rd_valid  (link_valid),
    .rd_target (link_target),
    .lw_en     (learn_en),
    .lw_set    (set_of(prev_line_q)),
    .lw_way    (prev_way_q),
    .lw_target (learn_target),
    .fill_en   (fill_done),
    .fill_set  (pend_set),
    .fill_way  (victim)
  );

  wm_victim_rr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_set (pend_set),
    .advance (fill_done),
    .victim  (victim)
  );

  // ---------------- control and response ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_LOOKUP;
      prev_ok_q     <= 1'b0;
      prev_line_q   <= '0;
      prev_way_q    <= '0;
      pend_line_q   <= '0;
      pend_off_q    <= '0;
      pend_seq_q    <= 1'b0;
      resp_valid    <= 1'b0;
      resp_data     <= '0;
      resp_way      <= '0;
      resp_memo     <= 1'b0;
      resp_tag_cmps <= '0;
      resp_way_ens  <= '0;
      evict_valid   <= 1'b0;
      evict_set     <= '0;
      evict_way     <= '0;
    end else begin
      resp_valid  <= 1'b0;
      evict_valid <= 1'b0;
      if (state_q == ST_LOOKUP) begin
        if (acc_hit) begin
          resp_valid    <= 1'b1;
          resp_data     <= rd_word;
          resp_way      <= use_way;
          resp_memo     <= memo_use;
          resp_tag_cmps <= memo_use ? CNT_W'(0) : CNT_W'(WAYS);
          resp_way_ens  <= memo_use ? CNT_W'(1) : CNT_W'(WAYS);
          prev_ok_q     <= 1'b1;
          prev_line_q   <= cur_line;
          prev_way_q    <= use_way;
        end else if (acc_miss) begin
          state_q     <= ST_REFILL;
          pend_line_q <= cur_line;
          pend_off_q  <= cur_off;
          pend_seq_q  <= seq_cross;
        end
      end else if (mem_ack) begin
        state_q       <= ST_LOOKUP;
        resp_valid    <= 1'b1;
        resp_data     <= word_of(mem_rdata, pend_off_q);
        resp_way      <= victim;
        resp_memo     <= 1'b0;
        resp_tag_cmps <= CNT_W'(WAYS);
        resp_way_ens  <= CNT_W'(WAYS);
        evict_valid   <= 1'b1;
        evict_set     <= pend_set;
        evict_way     <= victim;
        prev_ok_q     <= 1'b1;
        prev_line_q   <= pend_line_q;
        prev_way_q    <= victim;
      end
    end
  end

endmodule

// File: rtl/wm_icache_chk.sv
module wm_icache_chk #(
  parameter int WAYS   = 4,
  parameter int LINE_W = 10,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_ready,
  input logic              resp_valid,
  input logic              resp_memo,
  input logic [CNT_W-1:0]  resp_tag_cmps,
  input logic [CNT_W-1:0]  resp_way_ens,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [LINE_W-1:0] mem_line,
  input logic              evict_valid,
  input logic              acc_hit,
  input logic              acc_miss,
  input logic              fill_done,
  input logic              memo_use,
  input logic [WAYS-1:0]   way_en
);

  // R3
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line)));

  // R3
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> (mem_req && !fetch_ready && !resp_valid));

  // R5
  fill_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (evict_valid && resp_valid && !resp_memo));

  // R5
  evict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> !evict_valid);

  // R8
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memo_use |-> ($countones(way_en) == 1));

  // R2
  compare_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_memo) |-> (resp_tag_cmps == CNT_W'(WAYS) && resp_way_ens == CNT_W'(WAYS)));

  // R11
  memo_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && memo_use) |=> (resp_valid && resp_memo && resp_tag_cmps == '0));

endmodule

bind waymemo_icache wm_icache_chk #(.WAYS(WAYS), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_ready   (fetch_ready),
  .resp_valid    (resp_valid),
  .resp_memo     (resp_memo),
  .resp_tag_cmps (resp_tag_cmps),
  .resp_way_ens  (resp_way_ens),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_line      (mem_line),
  .evict_valid   (evict_valid),
  .acc_hit       (acc_hit),
  .acc_miss      (acc_miss),
  .fill_done     (fill_done),
  .memo_use      (memo_use),
  .way_en        (way_en)
);

// File: tb/sim_waymemo_icache.sv
`timescale 1ns/1ps
module sim_waymemo_icache;

  localparam int LAT = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [11:0]  fetch_addr = '0;
  logic         fetch_hint_valid = 1'b0;
  logic [1:0]   fetch_hint_way = '0;
  logic         fetch_ready;
  logic         resp_valid;
  logic [31:0]  resp_data;
  logic [1:0]   resp_way;
  logic         resp_memo;
  logic [2:0]   resp_tag_cmps;
  logic [2:0]   resp_way_ens;
  logic         mem_req;
  logic [9:0]   mem_line;
  logic         mem_ack;
  logic [127:0] mem_rdata;
  logic         evict_valid;
  logic [2:0]   evict_set;
  logic [1:0]   evict_way;

  int checks = 0;
  int fails  = 0;
  int mcnt;

  always #2.5 clk = ~clk;

  waymemo_icache u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_hint_valid(fetch_hint_valid), .fetch_hint_way(fetch_hint_way),
    .fetch_ready(fetch_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_way(resp_way),
    .resp_memo(resp_memo), .resp_tag_cmps(resp_tag_cmps), .resp_way_ens(resp_way_ens),
    .mem_req(mem_req), .mem_line(mem_line), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .evict_valid(evict_valid), .evict_set(evict_set), .evict_way(evict_way)
  );

  function automatic logic [31:0] exp_word(input logic [11:0] a);
    return 32'h5A00_0000 | {20'h0, a};
  endfunction

  // Fixed-latency memory model.
  always_comb begin
    for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = exp_word({mem_line, 2'(k)});
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt    <= 0;
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (mcnt == LAT - 1) begin
          mem_ack <= 1'b1;
          mcnt    <= 0;
        end else begin
          mcnt <= mcnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One fetch; checks data, way, memo flag, costs, latency and eviction report.
  task automatic do_fetch(input logic [11:0] a, input logic hv, input logic [1:0] hw,
                          input string req, input logic [1:0] ew, input logic em,
                          input int elat);
    int lat;
    @(negedge clk);
    fetch_valid      = 1'b1;
    fetch_addr       = a;
    fetch_hint_valid = hv;
    fetch_hint_way   = hw;
    while (!fetch_ready) @(negedge clk);
    @(posedge clk);
    #1;
    fetch_valid      = 1'b0;
    fetch_hint_valid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!resp_valid && lat < 40);
    check(lat == elat, req, "latency", lat, elat);
    check(resp_data == exp_word(a), req, "data", resp_data, exp_word(a));
    check(resp_way == ew, req, "way", resp_way, ew);
    check(resp_memo == em, req, "memo", resp_memo, em);
    check(resp_tag_cmps == (em ? 3'd0 : 3'd4), req, "tag_cmps", resp_tag_cmps, em ? 0 : 4);
    check(resp_way_ens == (em ? 3'd1 : 3'd4), req, "way_ens", resp_way_ens, em ? 1 : 4);
    if (elat > 1) begin
      check(evict_valid == 1'b1, req, "evict_valid", evict_valid, 1);
      check(evict_set == a[4:2], req, "evict_set", evict_set, a[4:2]);
      check(evict_way == ew, req, "evict_way", evict_way, ew);
    end else begin
      check(evict_valid == 1'b0, req, "evict_valid", evict_valid, 0);
    end
  endtask

  localparam int MISS = LAT + 2;

  task automatic t_reset();
    // R1
    check(fetch_ready == 1'b1, "R1", "fetch_ready", fetch_ready, 1);
    check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
    check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
    check(evict_valid == 1'b0, "R1", "evict_valid", evict_valid, 0);
  endtask

  task automatic t_cold_and_same();
    do_fetch(12'h000, 0, 0, "R3", 2'd0, 0, MISS);   // cold miss, way 0
    do_fetch(12'h003, 0, 0, "R6", 2'd0, 1, 1);      // same line reuse
  endtask

  task automatic t_learn_and_use();
    do_fetch(12'h004, 0, 0, "R7", 2'd0, 0, MISS);   // crossing, link learned by refill
    do_fetch(12'h002, 0, 0, "R2", 2'd0, 0, 1);      // plain tag compare hit
    do_fetch(12'h005, 0, 0, "R8", 2'd0, 1, 1);      // crossing served by link
  endtask

  task automatic t_stream();
    // R11: eight fetches back to back, one response per cycle.
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(resp_valid == 1'b1, "R11", "stream resp_valid", resp_valid, 1);
        check(resp_data == exp_word(12'(i - 1)), "R11", "stream data",
              resp_data, exp_word(12'(i - 1)));
        check(resp_memo == (i != 1), "R11", "stream memo", resp_memo, i != 1);
      end
      if (i < 8) begin
        check(fetch_ready == 1'b1, "R11", "stream ready", fetch_ready, 1);
        fetch_valid = 1'b1;
        fetch_addr  = 12'(i);
      end else begin
        fetch_valid = 1'b0;
      end
    end
  endtask

  task automatic t_hint();
    // R9: previous line is 1, line 0 is neither same nor successor.
    do_fetch(12'h002, 1, 2'd0, "R9", 2'd0, 1, 1);
  endtask

  task automatic t_rr_and_invalidate();
    do_fetch(12'h024, 0, 0, "R4", 2'd1, 0, MISS);
    do_fetch(12'h044, 0, 0, "R4", 2'd2, 0, MISS);
    do_fetch(12'h064, 0, 0, "R4", 2'd3, 0, MISS);
    do_fetch(12'h084, 0, 0, "R5", 2'd0, 0, MISS);   // wraps, overwrites line 1
    do_fetch(12'h000, 0, 0, "R2", 2'd0, 0, 1);
    do_fetch(12'h004, 0, 0, "R10", 2'd1, 0, MISS);  // stale link must not be used
    do_fetch(12'h002, 0, 0, "R2", 2'd0, 0, 1);
    do_fetch(12'h006, 0, 0, "R8", 2'd1, 1, 1);      // relearned link
  endtask

  task automatic t_set_wrap();
    do_fetch(12'h01C, 0, 0, "R3", 2'd0, 0, MISS);   // line 7, set 7
    do_fetch(12'h020, 0, 0, "R7", 2'd1, 0, MISS);   // line 8, set 0 way 1
    do_fetch(12'h01D, 0, 0, "R2", 2'd0, 0, 1);
    do_fetch(12'h021, 0, 0, "R7", 2'd1, 1, 1);      // link across set wrap
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_and_same();
    t_learn_and_use();
    t_stream();
    t_hint();
    t_rr_and_invalidate();
    t_set_wrap();
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule